// File: doc/BRIEF.md
# Shift-Register Push-Down Stack

This block is a small last-in-first-out store of four words. The words sit in a chain of word-wide registers. The newest word always occupies the register nearest the output. A push moves every held word one register deeper and writes the incoming word into the top register. A pop moves every held word one register toward the output and fills the deepest register with zero. The data output is wired straight to the top register, so the current top word can be read with no read strobe.

A separate up/down counter tracks how many words are held. The empty and full flags are decoded from that counter, so the block needs no read or write pointers. One enable input gates all activity. A select input picks the operation: 0 means push and 1 means pop. A request that would overflow or underflow the stack is dropped. Reset is synchronous and clears everything.

Top module: `lifo_shift_stack`

## Requirements
- R1: After a synchronous reset (rst high at a rising edge), empty is 1, full is 0 and dout is 0.
- R2: While en is 0, dout, empty and full keep their values across a clock edge, whatever pop_sel and din are.
- R3: With en=1, pop_sel=0 and full=0, din appears on dout after the rising edge, and the occupancy count rises by one.
- R4: With en=1, pop_sel=1 and empty=0, the word pushed just before the current top appears on dout after the edge, or zero if only one word was held. The count falls by one, and the deepest register is refilled with zero.
- R5: Words come out in the reverse of the order in which they were pushed.
- R6: empty is 1 exactly when the count is zero.
- R7: full is 1 exactly when the count equals DEPTH (four). empty and full are never 1 together.
- R8: A push while full is ignored: dout and full are unchanged, and later pops return the four words that were held before the push.
- R9: A pop while empty is ignored: empty stays 1 and dout stays 0.
- R10: Whenever empty is 1, dout is 0.
- R11: Reset asserted while words are held clears the stack, and the next edges behave as from R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Operation enable; 0 holds all state |
| pop_sel | input | 1 | Operation select: 0 push, 1 pop |
| din | input | WIDTH | Word to push |
| dout | output | WIDTH | Current top-of-stack word (0 when empty) |
| empty | output | 1 | High when no word is held |
| full | output | 1 | High when DEPTH words are held |

## Verification
The assertions take two things for granted. First, rst is high from time zero until the first edge. Second, en, pop_sel and din are settled before each rising edge, so each property can compare the values after the edge with the request made before it. The bench changes inputs only on the falling edge. It holds reset from the start. It mixes seeded random push, pop and idle requests with directed runs that overfill the stack, drain it past empty, and reset it while it holds words. A reference model inside the bench gives the expected top word and flags after every edge.

// File: rtl/lifo_stack_pkg.sv
package lifo_stack_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } stack_op_e;
endpackage

// File: rtl/stack_shift_chain.sv
module stack_shift_chain
    import lifo_stack_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  stack_op_e        op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] top
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] slot;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        case (op)
            OP_PUSH: begin
                chain_d.slot[0] = din;
                for (int i = 1; i < DEPTH; i++) begin
                    chain_d.slot[i] = chain_q.slot[i-1];
                end
            end
            OP_POP: begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    chain_d.slot[i] = chain_q.slot[i+1];
                end
                chain_d.slot[DEPTH-1] = '0;
            end
            default: chain_d = chain_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign top = chain_q.slot[0];

    // R4: after a pop, the old second word sits at the top
    assert_pop_shift_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_POP) |=> (top == $past(chain_q.slot[1])));
endmodule

// File: rtl/stack_occupancy.sv
module stack_occupancy #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic empty,
    output logic full
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } occ_t;

    occ_t occ_d, occ_q;

    always_comb begin
        occ_d = occ_q;
        if (inc && !dec) begin
            occ_d.count = occ_q.count + 1'b1;
        end else if (dec && !inc) begin
            occ_d.count = occ_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_d;
        end
    end

    assign empty = (occ_q.count == '0);
    assign full  = (occ_q.count == CNT_MAX);

    // R7: the count never passes the depth
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        occ_q.count <= CNT_MAX);
    // R7: the flags are never high together
    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));
    // R6: one increment from empty clears the empty flag
    assert_leave_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (empty && inc && !dec) |=> !empty);
endmodule

// File: rtl/lifo_shift_stack.sv
module lifo_shift_stack
    import lifo_stack_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             pop_sel,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    stack_op_e op;
    logic      do_push, do_pop;

    always_comb begin
        do_push = en && !pop_sel && !full;
        do_pop  = en && pop_sel && !empty;
        if (do_push) begin
            op = OP_PUSH;
        end else if (do_pop) begin
            op = OP_POP;
        end else begin
            op = OP_HOLD;
        end
    end

    stack_shift_chain #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chain (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .din (din),
        .top (dout)
    );

    stack_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk   (clk),
        .rst   (rst),
        .inc   (do_push),
        .dec   (do_pop),
        .empty (empty),
        .full  (full)
    );

    // R1: reset leaves an empty, zeroed stack
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (empty && !full && dout == '0));
    // R2: idle cycles change nothing visible
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(dout) && $stable(empty) && $stable(full)));
    // R3: an accepted push shows the input word on top
    assert_push_top_R3: assert property (@(posedge clk) disable iff (rst)
        (en && !pop_sel && !full) |=> (dout == $past(din) && !empty));
    // R8: a push while full leaves the top and the flag alone
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (en && !pop_sel && full) |=> (full && $stable(dout)));
    // R9: a pop while empty keeps the stack empty
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
        (en && pop_sel && empty) |=> empty);
    // R10: the output is zero whenever the stack is empty
    assert_empty_zero_R10: assert property (@(posedge clk) disable iff (rst)
        empty |-> (dout == '0));
endmodule

// File: tb/lifo_shift_stack_test.sv
`timescale 1ns/1ps
module lifo_shift_stack_test;
    localparam int W = 8;
    localparam int D = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         pop_sel = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         empty, full;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [W-1:0] m [D];
    int           mc;

    always #5 clk = ~clk;

    lifo_shift_stack #(.WIDTH(W), .DEPTH(D)) uut (
        .clk(clk), .rst(rst), .en(en), .pop_sel(pop_sel),
        .din(din), .dout(dout), .empty(empty), .full(full)
    );

    function automatic logic [W-1:0] exp_top();
        return m[0];
    endfunction

    function automatic logic exp_empty();
        return mc == 0;
    endfunction

    function automatic logic exp_full();
        return mc == D;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < D; i++) m[i] = '0;
        mc = 0;
    endtask

    // apply one cycle, update the model, then check the ports
    task automatic step(logic e, logic p, logic [W-1:0] d);
        string tag;
        @(negedge clk);
        en = e; pop_sel = p; din = d;
        tag = "R2";
        if (e && !p) tag = (mc == D) ? "R8" : "R3";
        if (e && p)  tag = (mc == 0) ? "R9" : "R4";
        @(posedge clk);
        #1;
        if (e && !p && mc < D) begin
            for (int i = D - 1; i > 0; i--) m[i] = m[i-1];
            m[0] = d;
            mc++;
        end else if (e && p && mc > 0) begin
            for (int i = 0; i < D - 1; i++) m[i] = m[i+1];
            m[D-1] = '0;
            mc--;
        end
        check({tag, " dout"}, 32'(dout), 32'(exp_top()));
        check("R6 empty", 32'(empty), 32'(exp_empty()));
        check("R7 full", 32'(full), 32'(exp_full()));
        if (empty) check("R10 zero when empty", 32'(dout), 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0;
        @(posedge clk);
        #1;
        model_clear();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5A17));
        model_clear();
        @(posedge clk);
        #1;
        check("R1 empty", 32'(empty), 32'd1);
        check("R1 full", 32'(full), 32'd0);
        check("R1 dout", 32'(dout), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R9: pop an empty stack
        step(1'b1, 1'b1, 8'hEE);
        step(1'b1, 1'b1, 8'h00);
        // R2: idle with toggling inputs
        step(1'b0, 1'b0, 8'h77);
        step(1'b0, 1'b1, 8'h66);
        // R5: fill, then drain in reverse order
        step(1'b1, 1'b0, 8'h23);
        step(1'b1, 1'b0, 8'h34);
        step(1'b1, 1'b0, 8'h45);
        step(1'b1, 1'b0, 8'h56);
        check("R7 full after four", 32'(full), 32'd1);
        // R8: overflow attempts
        step(1'b1, 1'b0, 8'hAA);
        step(1'b1, 1'b0, 8'hBB);
        step(1'b0, 1'b1, 8'h00);
        step(1'b1, 1'b1, 8'h00);
        check("R5 order 1", 32'(dout), 32'h45);
        step(1'b1, 1'b1, 8'h00);
        check("R5 order 2", 32'(dout), 32'h34);
        step(1'b1, 1'b1, 8'h00);
        check("R5 order 3", 32'(dout), 32'h23);
        step(1'b1, 1'b1, 8'h00);
        check("R4 drained", 32'(empty), 32'd1);
        step(1'b1, 1'b1, 8'h00);

        // R11: reset while holding words
        step(1'b1, 1'b0, 8'h11);
        step(1'b1, 1'b0, 8'h22);
        do_reset();
        check("R11 empty", 32'(empty), 32'd1);
        check("R11 dout", 32'(dout), 32'd0);
        step(1'b1, 1'b1, 8'h00);
        step(1'b1, 1'b0, 8'h99);
        check("R11 push after reset", 32'(dout), 32'h99);

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic e, p;
            logic [W-1:0] d;
            e = ($urandom % 5) != 0;
            p = ($urandom % 2) != 0;
            d = W'($urandom);
            step(e, p, d);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule